// File: doc/BRIEF.md
# STN Panel Line and Frame Timing Generator

This block turns a stream of display bytes into the drive signals of a passive-matrix STN panel. It takes display data from a fetch interface, one beat at a time. Each beat carries one byte for the upper half of the screen and one byte for the lower half. The block places the data on an 8-bit panel data bus and marks each transfer with a shift clock. It supports a single-scan panel with a 4-bit or an 8-bit bus. It also supports a dual-scan panel, where the two half-screen streams share the bus as two nibbles.

After the last transfer of a row, the block issues a line latch pulse. The width of this pulse comes from a configuration input, which lets the frame rate be tuned. During the latch pulse of the first row of a frame, it also raises a frame marker. An AC alternation output inverts after a programmable number of rows. Its row counter can either restart at every frame or run freely across frames. Configuration is expected to be held steady outside reset.

Top module: `lcd_line_timer`

## Requirements
- R1: While reset is asserted, `lcd_cp`, `lcd_vd`, `lcd_lp`, `lcd_flm` and `lcd_m` are all 0 and `in_ready` is 1.
- R2: Each transfer puts a new value on `lcd_vd` at least one clock before `lcd_cp` rises. `lcd_cp` stays high for exactly one clock. In single-scan 8-bit mode (`cfg_dual`=0, `cfg_wide`=1), one transfer carries `in_up[7:0]`. In single-scan 4-bit mode (`cfg_dual`=0, `cfg_wide`=0), a beat gives two transfers. These are `{4'h0,in_up[7:4]}` and then `{4'h0,in_up[3:0]}`.
- R3: In dual-scan mode (`cfg_dual`=1), a beat gives two transfers whatever `cfg_wide` is set to. These are `{in_lo[7:4],in_up[7:4]}` and then `{in_lo[3:0],in_up[3:0]}`, so the upper screen drives `lcd_vd[3:0]` and the lower screen drives `lcd_vd[7:4]`.
- R4: Each line latch pulse follows exactly H_PIX/8 beats' worth of transfers. That is H_PIX/8 transfers in single-scan 8-bit mode and H_PIX/4 in the other two modes.
- R5: `lcd_lp` stays high for `cfg_lpw` clocks, and a value of 0 acts as 1. `lcd_lp` only changes on a falling clock edge.
- R6: While `lcd_lp` is high, `lcd_cp` is low and `lcd_vd` does not change.
- R7: `lcd_flm` is high together with the latch pulse of row 0 of each frame and is low at all other times. A frame has V_LINES rows in single-scan mode and V_LINES/2 rows in dual-scan mode, and the row count wraps after the last row.
- R8: `lcd_m` inverts at the end of every `cfg_ac_lines`-th latch pulse, and a value of 0 acts as 1. It changes at no other time.
- R9: When `cfg_ac_frame_rst`=1, the alternation row count restarts at the end of the last row of each frame. When `cfg_ac_frame_rst`=0, it runs on across frame boundaries.
- R10: While no beat is held, `lcd_cp` stays low and no transfer is consumed. `in_ready` is 1 exactly when the one-beat holding buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dual | input | 1 | 1 selects a dual-scan panel |
| cfg_wide | input | 1 | 1 selects the 8-bit bus in single-scan mode |
| cfg_lpw | input | LPW_W | Line latch pulse width in clocks |
| cfg_ac_lines | input | AC_W | Rows between inversions of the alternation signal |
| cfg_ac_frame_rst | input | 1 | 1 restarts the alternation row count at each frame |
| in_valid | input | 1 | A display beat is offered |
| in_ready | output | 1 | The block takes the offered beat at this clock |
| in_up | input | 8 | Upper-screen byte (the only screen in single-scan mode) |
| in_lo | input | 8 | Lower-screen byte, used in dual-scan mode |
| lcd_cp | output | 1 | Shift clock; the panel samples on its rising edge |
| lcd_vd | output | 8 | Panel data bus |
| lcd_lp | output | 1 | Line latch pulse |
| lcd_flm | output | 1 | First-row frame marker |
| lcd_m | output | 1 | AC alternation signal |

## Verification
The bench builds the block with H_PIX=32 and V_LINES=6. This gives four beats per row, six rows per frame in single-scan mode and three in dual-scan mode. Frame wrap, repeated frame markers and alternation counts that cross frame boundaries therefore all occur within a few hundred clocks. Four configurations are used. They cover all three bus modes, a latch width of 0 as well as wider pulses, and alternation periods both shorter and longer than a frame, with and without the per-frame restart. Stalls in the middle of a row exercise the empty-buffer hold.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic {SEQ_SHIFT = 1'b0, SEQ_LATCH = 1'b1} seq_state_e;

  // transfers produced by one fetched beat
  function automatic logic [1:0] slots_per_beat(input logic dual, input logic wide);
    return (wide && !dual) ? 2'd1 : 2'd2;
  endfunction

  // bus value for one transfer; sub selects the low nibble half of the beat
  function automatic logic [7:0] slot_bus(input logic [7:0] up, input logic [7:0] lo,
                                          input logic dual, input logic wide, input logic sub);
    logic [3:0] un;
    logic [3:0] ln;
    un = sub ? up[3:0] : up[7:4];
    ln = sub ? lo[3:0] : lo[7:4];
    if (dual) return {ln, un};
    else if (wide) return up;
    else return {4'h0, un};
  endfunction

  // a programmed count of zero behaves as one
  function automatic logic [15:0] at_least_one(input logic [15:0] v);
    return (v == 16'd0) ? 16'd1 : v;
  endfunction
endpackage

// File: rtl/lcd_slot_shift.sv
module lcd_slot_shift
  import lcd_tim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_dual,
  input  logic       cfg_wide,
  input  logic       shift_en,
  input  logic       more_slots,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_up,
  input  logic [7:0] in_lo,
  output logic       slot_load,
  output logic       busy,
  output logic       cp,
  output logic [7:0] vd
);
  timeunit 1ns;
  timeprecision 100ps;

  logic       have_q, sub_q, pend_q, cp_q;
  logic [7:0] up_q, lo_q, vd_q;
  logic       accept, last_sub;

  assign in_ready  = !have_q;
  assign accept    = in_valid && !have_q;
  assign last_sub  = (slots_per_beat(cfg_dual, cfg_wide) == 2'd1) || sub_q;
  assign slot_load = shift_en && more_slots && have_q && !pend_q;
  assign busy      = pend_q || cp_q;
  assign cp        = cp_q;
  assign vd        = vd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      sub_q  <= 1'b0;
      pend_q <= 1'b0;
      cp_q   <= 1'b0;
      up_q   <= 8'h00;
      lo_q   <= 8'h00;
      vd_q   <= 8'h00;
    end else begin
      if (accept) begin
        have_q <= 1'b1;
        up_q   <= in_up;
        lo_q   <= in_lo;
        sub_q  <= 1'b0;
      end else if (slot_load) begin
        vd_q <= slot_bus(up_q, lo_q, cfg_dual, cfg_wide, sub_q);
        if (last_sub) have_q <= 1'b0;
        else          sub_q  <= 1'b1;
      end
      // two-clock transfer: data set with CP low, then CP high for one clock
      if (cp_q) begin
        cp_q <= 1'b0;
      end else if (pend_q) begin
        cp_q   <= 1'b1;
        pend_q <= 1'b0;
      end
      if (slot_load) pend_q <= 1'b1;
    end
  end

  AST_CP_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) cp_q |=> !cp_q); // R2
  AST_VD_SETUP_AT_CP: assert property (@(posedge clk) disable iff (!rst_n) $rose(cp_q) |-> $stable(vd_q)); // R2
  AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (cp_q && !cfg_dual && !cfg_wide) |-> (vd_q[7:4] == 4'h0)); // R2
  AST_EMPTY_HOLDS_CP: assert property (@(posedge clk) disable iff (!rst_n) (!have_q && !pend_q && !cp_q) |=> !cp_q); // R10
endmodule

// File: rtl/lcd_line_seq.sv
module lcd_line_seq
  import lcd_tim_pkg::*;
#(
  parameter int BEATS   = 40,
  parameter int V_LINES = 240,
  parameter int SLOT_W  = 7,
  parameter int LINE_W  = 8,
  parameter int LPW_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dual,
  input  logic             cfg_wide,
  input  logic [LPW_W-1:0] cfg_lpw,
  input  logic             slot_load,
  input  logic             busy,
  output logic             shift_en,
  output logic             more_slots,
  output logic             lp_core,
  output logic             flm_core,
  output logic             line_end,
  output logic             frame_end
);
  timeunit 1ns;
  timeprecision 100ps;

  seq_state_e        state_q;
  logic [SLOT_W-1:0] load_cnt_q;
  logic [LPW_W-1:0]  lp_cnt_q;
  logic [LINE_W-1:0] line_q;
  logic [SLOT_W-1:0] slots_line;
  logic [LINE_W-1:0] lines_frame;
  logic              line_sent;

  assign slots_line  = (slots_per_beat(cfg_dual, cfg_wide) == 2'd1) ?
                       SLOT_W'(BEATS) : SLOT_W'(2 * BEATS);
  assign lines_frame = cfg_dual ? LINE_W'(V_LINES / 2) : LINE_W'(V_LINES);

  assign shift_en   = (state_q == SEQ_SHIFT);
  assign more_slots = (load_cnt_q < slots_line);
  assign line_sent  = shift_en && !more_slots && !busy;
  assign lp_core    = (state_q == SEQ_LATCH);
  assign flm_core   = lp_core && (line_q == '0);
  assign line_end   = lp_core &&
                      (16'(lp_cnt_q) == at_least_one(16'(cfg_lpw)) - 16'd1);
  assign frame_end  = line_end && (line_q == lines_frame - LINE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SEQ_SHIFT;
      load_cnt_q <= '0;
      lp_cnt_q   <= '0;
      line_q     <= '0;
    end else if (state_q == SEQ_SHIFT) begin
      if (slot_load) load_cnt_q <= load_cnt_q + SLOT_W'(1);
      if (line_sent) begin
        state_q  <= SEQ_LATCH;
        lp_cnt_q <= '0;
      end
    end else begin
      if (line_end) begin
        state_q    <= SEQ_SHIFT;
        load_cnt_q <= '0;
        line_q     <= frame_end ? '0 : line_q + LINE_W'(1);
      end else begin
        lp_cnt_q <= lp_cnt_q + LPW_W'(1);
      end
    end
  end

  AST_LINE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) line_q < lines_frame); // R7
  AST_SLOTS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) load_cnt_q <= slots_line); // R4
  AST_LATCH_SHIFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n) lp_core |-> !busy); // R6
endmodule

// File: rtl/lcd_ac_gen.sv
module lcd_ac_gen
  import lcd_tim_pkg::*;
#(
  parameter int AC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AC_W-1:0] cfg_ac_lines,
  input  logic            cfg_ac_frame_rst,
  input  logic            line_end,
  input  logic            frame_end,
  output logic            m
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [AC_W-1:0] ac_cnt_q;
  logic            m_q;
  logic            period_hit;

  assign period_hit = (16'(ac_cnt_q) + 16'd1) == at_least_one(16'(cfg_ac_lines));
  assign m = m_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_cnt_q <= '0;
      m_q      <= 1'b0;
    end else if (line_end) begin
      if (period_hit) begin
        m_q      <= ~m_q;
        ac_cnt_q <= '0;
      end else if (frame_end && cfg_ac_frame_rst) begin
        ac_cnt_q <= '0;
      end else begin
        ac_cnt_q <= ac_cnt_q + AC_W'(1);
      end
    end
  end

  AST_M_ONLY_AT_LINE_END: assert property (@(posedge clk) disable iff (!rst_n) !line_end |=> $stable(m_q)); // R8
  AST_AC_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) 16'(ac_cnt_q) < at_least_one(16'(cfg_ac_lines))); // R8
  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (frame_end && cfg_ac_frame_rst) |=> (ac_cnt_q == '0)); // R9
endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer
  import lcd_tim_pkg::*;
#(
  parameter int H_PIX   = 320,
  parameter int V_LINES = 240,
  parameter int LPW_W   = 8,
  parameter int AC_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dual,
  input  logic             cfg_wide,
  input  logic [LPW_W-1:0] cfg_lpw,
  input  logic [AC_W-1:0]  cfg_ac_lines,
  input  logic             cfg_ac_frame_rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_up,
  input  logic [7:0]       in_lo,
  output logic             lcd_cp,
  output logic [7:0]       lcd_vd,
  output logic             lcd_lp,
  output logic             lcd_flm,
  output logic             lcd_m
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int BEATS  = H_PIX / 8;
  localparam int SLOT_W = $clog2(2 * BEATS + 1);
  localparam int LINE_W = $clog2(V_LINES);

  logic shift_en, more_slots, slot_load, busy;
  logic lp_core, flm_core, line_end, frame_end;
  logic lp_q, flm_q;

  lcd_slot_shift u_shift (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_wide(cfg_wide),
    .shift_en(shift_en), .more_slots(more_slots),
    .in_valid(in_valid), .in_ready(in_ready), .in_up(in_up), .in_lo(in_lo),
    .slot_load(slot_load), .busy(busy), .cp(lcd_cp), .vd(lcd_vd)
  );

  lcd_line_seq #(
    .BEATS(BEATS), .V_LINES(V_LINES), .SLOT_W(SLOT_W), .LINE_W(LINE_W), .LPW_W(LPW_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_wide(cfg_wide), .cfg_lpw(cfg_lpw),
    .slot_load(slot_load), .busy(busy), .shift_en(shift_en), .more_slots(more_slots),
    .lp_core(lp_core), .flm_core(flm_core), .line_end(line_end), .frame_end(frame_end)
  );

  lcd_ac_gen #(.AC_W(AC_W)) u_ac (
    .clk(clk), .rst_n(rst_n), .cfg_ac_lines(cfg_ac_lines),
    .cfg_ac_frame_rst(cfg_ac_frame_rst), .line_end(line_end), .frame_end(frame_end),
    .m(lcd_m)
  );

  // latch pulse and frame marker are retimed onto the falling clock edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q  <= 1'b0;
      flm_q <= 1'b0;
    end else begin
      lp_q  <= lp_core;
      flm_q <= flm_core;
    end
  end

  assign lcd_lp  = lp_q;
  assign lcd_flm = flm_q;

  AST_CP_LOW_IN_LP: assert property (@(posedge clk) disable iff (!rst_n) (lp_core || lcd_lp) |-> !lcd_cp); // R6
  AST_VD_FROZEN_IN_LP: assert property (@(posedge clk) disable iff (!rst_n) (lp_core && $past(lp_core)) |-> $stable(lcd_vd)); // R6
  AST_FLM_INSIDE_LP: assert property (@(posedge clk) disable iff (!rst_n) lcd_flm |-> lcd_lp); // R7
endmodule

// File: tb/lcd_line_timer_bench.sv
module lcd_line_timer_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int H_PIX = 32;
  localparam int V_LINES = 6;
  localparam int BEATS = H_PIX / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c_dual = 1'b0, c_wide = 1'b1, c_frst = 1'b0;
  logic [7:0] c_lpw = 8'd1, c_ac = 8'd1;
  logic in_valid = 1'b0;
  logic [7:0] in_up = 8'h00, in_lo = 8'h00;
  logic in_ready, lcd_cp, lcd_lp, lcd_flm, lcd_m;
  logic [7:0] lcd_vd;

  always #2.5 clk = ~clk;

  lcd_line_timer #(.H_PIX(H_PIX), .V_LINES(V_LINES), .LPW_W(8), .AC_W(8)) u_lcd_line_timer (
    .clk(clk), .rst_n(rst_n), .cfg_dual(c_dual), .cfg_wide(c_wide), .cfg_lpw(c_lpw),
    .cfg_ac_lines(c_ac), .cfg_ac_frame_rst(c_frst), .in_valid(in_valid), .in_ready(in_ready),
    .in_up(in_up), .in_lo(in_lo), .lcd_cp(lcd_cp), .lcd_vd(lcd_vd), .lcd_lp(lcd_lp),
    .lcd_flm(lcd_flm), .lcd_m(lcd_m)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  int cp_in_line, cp_rises, lp_w, line_idx, ac_cnt, lines_seen;
  int lp_bad, m_bad, flm_bad, align_bad;
  logic m_exp, cp_prev, lp_prev, lpn;
  logic [7:0] vd_lp;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_slots();
    return BEATS * ((c_wide && !c_dual) ? 1 : 2);
  endfunction
  function automatic int exp_lines();
    return c_dual ? V_LINES / 2 : V_LINES;
  endfunction
  function automatic int eff(input logic [7:0] v);
    return (v == 8'd0) ? 1 : int'(v);
  endfunction

  // monitor: compares each transfer against the scoreboard and models LP/FLM/M
  initial begin
    forever begin
      @(negedge clk); #1 lpn = lcd_lp;
      @(posedge clk); #1;
      if (rst_n) begin
        if (lcd_lp !== lpn) align_bad++;
        if (lcd_cp && !cp_prev) begin
          cp_rises++;
          cp_in_line++;
          if (exp_q.size() == 0) check(0, c_dual ? "R3" : "R2", "unexpected transfer", lcd_vd, -1);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(lcd_vd == e, c_dual ? "R3" : "R2", "transfer data", lcd_vd, e);
          end
        end
        if (lcd_lp && !lp_prev) begin
          check(cp_in_line == exp_slots(), "R4", "transfers per line", cp_in_line, exp_slots());
          check(lcd_flm == (line_idx == 0), "R7", "frame marker at latch", lcd_flm, line_idx == 0);
          cp_in_line = 0;
          vd_lp = lcd_vd;
          lp_w = 0;
        end
        if (lcd_lp) begin
          lp_w++;
          if (lcd_cp || lcd_vd !== vd_lp) lp_bad++;
        end
        if (!lcd_lp && lp_prev) begin
          bit last;
          check(lp_w == eff(c_lpw), "R5", "latch pulse width", lp_w, eff(c_lpw));
          check(lp_bad == 0, "R6", "cp/vd activity during latch", lp_bad, 0);
          lp_bad = 0;
          last = (line_idx == exp_lines() - 1);
          ac_cnt++;
          if (ac_cnt == eff(c_ac)) begin m_exp = ~m_exp; ac_cnt = 0; end
          else if (c_frst && last) ac_cnt = 0;
          check(lcd_m == m_exp, c_frst ? "R9" : "R8", "alternation level", lcd_m, m_exp);
          line_idx = last ? 0 : line_idx + 1;
          lines_seen++;
        end else if (!lcd_lp) begin
          if (lcd_flm) flm_bad++;
          if (lcd_m !== m_exp) m_bad++;
        end
      end
      cp_prev = lcd_cp;
      lp_prev = lcd_lp;
    end
  end

  // driver: offers one beat and pushes the transfers it must produce
  task automatic send_beat(input logic [7:0] u, input logic [7:0] l);
    @(negedge clk);
    in_valid = 1'b1; in_up = u; in_lo = l;
    while (!in_ready) @(negedge clk);
    if (c_dual) begin
      exp_q.push_back({l[7:4], u[7:4]});
      exp_q.push_back({l[3:0], u[3:0]});
    end else if (c_wide) begin
      exp_q.push_back(u);
    end else begin
      exp_q.push_back({4'h0, u[7:4]});
      exp_q.push_back({4'h0, u[3:0]});
    end
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  task automatic run_case(input logic d, input logic w, input logic [7:0] lpw, input logic [7:0] ac,
                          input logic fr, input int nlines, input bit stall, input bit first);
    @(negedge clk);
    rst_n = 1'b0;
    c_dual = d; c_wide = w; c_lpw = lpw; c_ac = ac; c_frst = fr;
    exp_q.delete();
    cp_in_line = 0; cp_rises = 0; lp_w = 0; line_idx = 0; ac_cnt = 0; lines_seen = 0;
    lp_bad = 0; m_exp = 1'b0; cp_prev = 1'b0; lp_prev = 1'b0;
    repeat (3) @(negedge clk);
    if (first) begin
      check(lcd_cp == 0, "R1", "cp in reset", lcd_cp, 0);
      check(lcd_vd == 0, "R1", "vd in reset", lcd_vd, 0);
      check(lcd_lp == 0 && lcd_flm == 0, "R1", "lp/flm in reset", {lcd_lp, lcd_flm}, 0);
      check(lcd_m == 0, "R1", "m in reset", lcd_m, 0);
      check(in_ready == 1, "R1", "ready in reset", in_ready, 1);
    end
    rst_n = 1'b1;
    for (int ln = 0; ln < nlines; ln++) begin
      for (int b = 0; b < BEATS; b++) begin
        int k;
        k = ln * BEATS + b;
        send_beat(8'(k * 37 + 5), 8'(k * 91 + 3) ^ 8'hA5);
        if (stall && ln == 1 && b == 1) begin
          int snap;
          while (!in_ready) @(negedge clk);
          repeat (6) @(negedge clk);
          snap = cp_rises;
          repeat (20) @(negedge clk);
          check(cp_rises == snap && !lcd_cp, "R10", "transfers while starved", cp_rises - snap, 0);
          check(in_ready == 1, "R10", "ready while buffer empty", in_ready, 1);
        end
      end
    end
    while (lines_seen < nlines) @(posedge clk);
    repeat (10) @(posedge clk);
    check(exp_q.size() == 0, "R4", "transfers left unsent", exp_q.size(), 0);
  endtask

  initial begin
    m_bad = 0; flm_bad = 0; align_bad = 0;
    run_case(1'b0, 1'b1, 8'd3, 8'd2, 1'b0, 12, 1'b0, 1'b1);
    run_case(1'b0, 1'b0, 8'd0, 8'd5, 1'b1, 8, 1'b1, 1'b0);
    run_case(1'b1, 1'b1, 8'd2, 8'd4, 1'b1, 7, 1'b0, 1'b0);
    run_case(1'b1, 1'b0, 8'd5, 8'd4, 1'b0, 9, 1'b1, 1'b0);
    check(m_bad == 0, "R8", "alternation changed between latches", m_bad, 0);
    check(flm_bad == 0, "R7", "frame marker outside latch", flm_bad, 0);
    check(align_bad == 0, "R5", "latch changed on rising edge", align_bad, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule